// File: doc/BRIEF.md
# Receive Character Compare and Action Unit

This block sits on the receive side of a serial port and looks at every received byte. It holds three programmable 8-bit match characters. Each one has a 4-bit action mask. When a byte equals a match character, the mask decides what happens: raise an interrupt, drop the byte from the stream, halt the transmitter, or resume it. If a byte matches several entries, the actions of all of them apply together. The transmitter halt wins over the resume.

Software reaches the match characters and their action masks through one data port, chosen by a bank-select register. The block also keeps an 8-bit count of received bytes. The count covers bytes that were dropped. It can raise an interrupt for every byte received. A pending interrupt is reported on a single line and as a 5-bit cause code. Reading the cause register clears the pending interrupt.

The register interface has four addresses:

| Address | On write | On read |
|---------|----------|---------|
| 0 | Bank select | Bank select |
| 1 | Data port | Data port |
| 2 | Control | Byte count |
| 3 | — | Interrupt cause |

Top module: `rx_match_unit`

## Requirements
- R1: The bank select is at address 0. Bit 0 picks the register type: 1 means a match character and 0 means an action mask. Bits 2:1 pick the entry: 00, 01 and 10 select entries 0, 1 and 2. Bits 7:3 always read 0, so a write of 0xFF reads back as 0x07.
- R2: The data port is at address 1 and reads or writes the register chosen by the bank select. Match characters keep all 8 bits. Action masks keep bits 3:0, and bits 7:4 read 0. When the entry field is 11, the port reads 0 and a write to it changes nothing.
- R3: After reset:
  - All match characters, action masks and the bank select are 0.
  - The byte count is 0 and the count interrupt is off.
  - `tx_enable` is 1, and `irq` and `out_valid` are 0.
- R4: A received byte that is not dropped appears on `out_data`, with `out_valid` high for one cycle. This happens in the cycle after the one in which `rx_valid` is sampled high. `out_valid` is low in every other cycle.
- R5: A byte that matches an entry whose action mask has bit 1 set is dropped: `out_valid` stays low for it.
- R6: The byte count is read at address 2. It goes up by one for each sampled `rx_valid`, dropped bytes included, and wraps from 255 to 0.
- R7: A match on an entry whose action mask has bit 2 set drives `tx_enable` to 0. A match with bit 3 set drives it to 1. When both are requested, 0 wins. A byte that matches no entry leaves `tx_enable` unchanged.
- R8: A match on an entry whose action mask has bit 0 set raises `irq`. The cause code is 11000 for entry 0, 11001 for entry 1 and 11010 for entry 2. When several such entries match, the lowest entry sets the code. Address 3 reads the code in bits 5:1 and the pending flag in bit 0.
- R9: Writing bit 0 of the control register (address 2) turns on the count interrupt. While it is on, every received byte raises `irq` with code 10010. If the same byte also raises a match interrupt, the match code is the one reported.
- R10: A read of address 3 with `reg_rd` high clears `irq` in the next cycle. If an interrupt event arrives in that same cycle, `irq` stays high.
- R11: When a byte matches several entries, the drop, halt and resume actions of all matching entries are combined by OR.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | Received byte strobe, one cycle per byte |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; needed only to clear the interrupt |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from `reg_addr` |
| out_data | output | 8 | Filtered byte |
| out_valid | output | 1 | Filtered byte strobe |
| tx_enable | output | 1 | Transmitter enable |
| irq | output | 1 | Interrupt pending |
| irq_id | output | 5 | Interrupt cause code, valid while `irq` is high |

## Verification
The faults that matter most are a corrupted match character or action mask. Either one shows on the very next matching byte:
- a byte that should pass is missing from the output, or a byte that should be dropped is passed;
- `tx_enable` lands on the wrong level one cycle after the byte;
- the cause code is wrong at the following read of address 3.

The count drifts by one at each byte it misses. So its value is checked after long runs and at the wrap point. Reads through the data port expose each stored register directly, so a masking or bank-decode fault is visible as soon as that register is read.

// File: rtl/rx_match_unit.sv
module rx_match_unit #(
  parameter int NCHR = 3,
  parameter int DW   = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_valid,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic [DW-1:0] out_data,
  output logic          out_valid,
  output logic          tx_enable,
  output logic          irq,
  output logic [4:0]    irq_id
);
  localparam logic [1:0] A_SEL = 2'd0, A_PORT = 2'd1, A_CNT = 2'd2, A_ID = 2'd3;
  localparam logic [4:0] ID_CNT = 5'b10010;

  logic [2:0]    sel_q;
  logic [DW-1:0] chr_q [NCHR];
  logic [3:0]    fn_q  [NCHR];
  logic [DW-1:0] cnt_q;
  logic          cnt_ie_q;
  logic          tx_q, pend_q, ov_q;
  logic [4:0]    code_q;
  logic [DW-1:0] od_q;

  logic [1:0] idx;
  logic       idx_ok;
  assign idx    = sel_q[2:1];
  assign idx_ok = (int'(idx) < NCHR);

  logic [NCHR-1:0] hit;
  logic act_int, act_del, act_stop, act_start;
  logic [1:0] int_idx;
  always_comb begin
    act_int = 1'b0; act_del = 1'b0; act_stop = 1'b0; act_start = 1'b0;
    int_idx = 2'd0;
    for (int i = NCHR - 1; i >= 0; i--) begin
      hit[i] = (rx_data == chr_q[i]);
      if (hit[i]) begin
        act_del   = act_del   | fn_q[i][1];
        act_stop  = act_stop  | fn_q[i][2];
        act_start = act_start | fn_q[i][3];
        if (fn_q[i][0]) begin
          act_int = 1'b1;
          int_idx = 2'(i);
        end
      end
    end
  end

  logic rd_clear;
  assign rd_clear = reg_rd && reg_addr == A_ID;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      for (int i = 0; i < NCHR; i++) begin
        chr_q[i] <= '0;
        fn_q[i]  <= '0;
      end
      cnt_ie_q <= 1'b0;
    end else if (reg_wr) begin
      case (reg_addr)
        A_SEL: sel_q <= reg_wdata[2:0];
        A_PORT:
          if (idx_ok) begin
            if (sel_q[0]) chr_q[idx] <= reg_wdata;
            else          fn_q[idx]  <= reg_wdata[3:0];
          end
        A_CNT: cnt_ie_q <= reg_wdata[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tx_q   <= 1'b1;
      pend_q <= 1'b0;
      code_q <= '0;
      ov_q   <= 1'b0;
      od_q   <= '0;
    end else begin
      ov_q <= rx_valid && !act_del;
      if (rx_valid) begin
        od_q  <= rx_data;
        cnt_q <= cnt_q + 1'b1;
        if (act_stop)       tx_q <= 1'b0;
        else if (act_start) tx_q <= 1'b1;
      end
      if (rx_valid && act_int) begin
        pend_q <= 1'b1;
        code_q <= {3'b110, int_idx};
      end else if (rx_valid && cnt_ie_q) begin
        pend_q <= 1'b1;
        code_q <= ID_CNT;
      end else if (rd_clear) begin
        pend_q <= 1'b0;
      end
    end
  end

  always_comb begin
    case (reg_addr)
      A_SEL:  reg_rdata = {5'b0, sel_q};
      A_PORT: reg_rdata = !idx_ok ? '0 : sel_q[0] ? chr_q[idx] : {4'b0, fn_q[idx]};
      A_CNT:  reg_rdata = cnt_q;
      default: reg_rdata = {2'b0, code_q, pend_q};
    endcase
  end

  assign out_data  = od_q;
  assign out_valid = ov_q;
  assign tx_enable = tx_q;
  assign irq       = pend_q;
  assign irq_id    = code_q;

  AST_SEL_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr == A_SEL |-> reg_rdata[7:3] == 5'd0); // R1
  AST_FUNC_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_PORT && !sel_q[0]) |-> reg_rdata[7:4] == 4'd0); // R2
  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !act_del) |=> (out_valid && out_data == $past(rx_data))); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> !out_valid); // R4
  AST_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && act_del) |=> !out_valid); // R5
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> cnt_q == $past(cnt_q) + 8'd1); // R6
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> $stable(cnt_q)); // R6
  AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && act_stop) |=> !tx_enable); // R7
  AST_MATCH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && act_int) |=> (irq && irq_id[4:3] == 2'b11)); // R8
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clear && !rx_valid) |=> !irq); // R10
endmodule

// File: tb/rx_match_unit_tb.sv
`timescale 1ns/1ps
module rx_match_unit_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] rx_data = '0, reg_wdata = '0, reg_rdata, out_data;
  logic rx_valid = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_addr = '0;
  logic out_valid, tx_enable, irq;
  logic [4:0] irq_id;
  int n_chk = 0, n_bad = 0, n_rx = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rx_match_unit u_dut (.clk, .rst_n, .rx_data, .rx_valid, .reg_wr, .reg_rd,
    .reg_addr, .reg_wdata, .reg_rdata, .out_data, .out_valid, .tx_enable,
    .irq, .irq_id);

  // {byte, out_valid, tx_enable, irq, code}
  localparam logic [15:0] VEC [7] = '{
    {8'h10, 1'b1, 1'b1, 1'b0, 5'b00000},
    {8'h41, 1'b1, 1'b1, 1'b1, 5'b11000},
    {8'h42, 1'b0, 1'b0, 1'b0, 5'b00000},
    {8'h55, 1'b1, 1'b0, 1'b0, 5'b00000},
    {8'h43, 1'b1, 1'b1, 1'b1, 5'b11010},
    {8'h42, 1'b0, 1'b0, 1'b0, 5'b00000},
    {8'h41, 1'b1, 1'b0, 1'b1, 5'b11000}
  };

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic rdclr();
    @(negedge clk); reg_addr = 2'd3; reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic rx(logic [7:0] b);
    @(negedge clk); rx_data = b; rx_valid = 1'b1; n_rx++;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic setent(int i, logic [7:0] c, logic [3:0] f);
    wr(2'd0, {5'b0, 2'(i), 1'b1}); wr(2'd1, c);
    wr(2'd0, {5'b0, 2'(i), 1'b0}); wr(2'd1, {4'b0, f});
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    chk("R3 tx_enable", tx_enable, 1); chk("R3 irq", irq, 0); chk("R3 out_valid", out_valid, 0);
    rd(2'd2, d); chk("R3 count", d, 0);
    rd(2'd0, d); chk("R3 select", d, 0);
    rd(2'd1, d); chk("R3 func0", d, 0);
    rst_n = 1'b1;
    rd(2'd1, d); chk("R3 func0 after release", d, 0);

    wr(2'd0, 8'hFF); rd(2'd0, d); chk("R1 select mask", d, 8'h07);
    wr(2'd1, 8'h5A); rd(2'd1, d); chk("R2 entry 11 reads 0", d, 0);
    setent(0, 8'h41, 4'h1); setent(1, 8'h42, 4'h6); setent(2, 8'h43, 4'h9);
    wr(2'd0, 8'h00); wr(2'd1, 8'hF1); rd(2'd1, d); chk("R2 func mask", d, 8'h01);
    wr(2'd0, 8'h03); rd(2'd1, d); chk("R2 char1 readback", d, 8'h42);
    wr(2'd0, 8'h05); rd(2'd1, d); chk("R2 char2 readback", d, 8'h43);
    wr(2'd0, 8'h06); wr(2'd1, 8'hFF);
    wr(2'd0, 8'h01); rd(2'd1, d); chk("R2 entry 11 write ignored", d, 8'h41);

    for (int k = 0; k < 7; k++) begin
      rx(VEC[k][15:8]);
      chk("R4/R5 out_valid", out_valid, VEC[k][7]);
      if (VEC[k][7]) chk("R4 out_data", out_data, VEC[k][15:8]);
      chk("R7 tx_enable", tx_enable, VEC[k][6]);
      chk("R8 irq", irq, VEC[k][5]);
      if (VEC[k][5]) begin
        rd(2'd3, d); chk("R8 cause read", d, {2'b0, VEC[k][4:0], 1'b1});
      end
      rdclr(); chk("R10 cleared", irq, 0);
    end

    rx(8'h43); rdclr();
    setent(2, 8'h99, 4'hC);
    rx(8'h99); chk("R7 stop beats start", tx_enable, 0); chk("R7 start+stop pass", out_valid, 1);
    rx(8'h43); chk("R7 no match unchanged", tx_enable, 0);

    setent(0, 8'h77, 4'h1); setent(1, 8'h77, 4'h7); setent(2, 8'h77, 4'h9);
    wr(2'd0, 8'h00); wr(2'd1, 8'h01);
    rx(8'h10); rx(8'h43);
    setent(1, 8'h42, 4'h0); setent(2, 8'h43, 4'h8);
    rx(8'h43); chk("R7 start sets", tx_enable, 1);
    setent(1, 8'h77, 4'h6); setent(2, 8'h77, 4'h9);
    rx(8'h77);
    chk("R11 drop from entry1", out_valid, 0);
    chk("R11 stop from entry1 over start", tx_enable, 0);
    rd(2'd3, d); chk("R8 lowest index code", d, {2'b0, 5'b11000, 1'b1});
    rdclr();

    wr(2'd2, 8'h01);
    rx(8'h20); chk("R9 count irq", irq, 1); chk("R9 count code", irq_id, 5'b10010);
    rx(8'h77); chk("R9 match wins code", irq_id, 5'b11000);
    @(negedge clk); reg_addr = 2'd3; reg_rd = 1'b1; rx_data = 8'h21; rx_valid = 1'b1; n_rx++;
    @(negedge clk); reg_rd = 1'b0; rx_valid = 1'b0;
    chk("R10 event beats clear", irq, 1);
    rdclr(); chk("R10 clear", irq, 0);
    wr(2'd2, 8'h00);
    rx(8'h22); chk("R9 disabled no irq", irq, 0);

    rd(2'd2, d); chk("R6 count incl dropped", d, 8'(n_rx));
    while (n_rx % 256 != 0) rx(8'h00);
    rd(2'd2, d); chk("R6 wrap to 0", d, 0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule